// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a physical page address. It uses a small set of block-translation entries. Each entry is a pair of 32-bit words. The upper word holds the effective block base, the block-length mask and two privilege-valid bits. The lower word holds the physical block base and the permission bits. Instruction fetches look only at the code set of entries, and data accesses look only at the data set.

A request is presented for one cycle. The block compares the address against every entry of the selected set in parallel. The lowest-numbered entry that matches and is usable at the current privilege level supplies the translation. The outcome comes back registered one cycle later, as exactly one of three results:

- a hit, carrying the physical page address and its read/write rights;
- a protection error;
- a miss, which lets a later page-table stage take over.

When translation is switched off for the access type, the address passes through with full rights. Entries are loaded through a one-word write port.

Top module: `bat_xlate`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_prot_err` are 0. Every entry word of both sets is cleared, so with translation enabled any lookup reports a miss.
- R2: A request sampled with `req_valid`=1 produces `rsp_valid`=1 on the next clock edge. With no request, `rsp_valid` and the three outcome flags are 0.
- R3: If translation is disabled for the access type, the response is a hit with `rsp_paddr` = `req_ea` with bits [11:0] cleared, and both read and write granted. Code accesses (`req_code`=1) use `xlate_code_en`; data accesses use `xlate_data_en`.
- R4: An entry matches when the address bits [31:28] equal upper bits [31:28]. In addition, the address bits [27:17], with the bits selected by the block-length mask cleared, must equal upper bits [27:17]. Upper bits [12:2] form this mask and line up with address bits [27:17].
- R5: An entry is usable for a supervisor access (`req_user`=0) only if upper bit 1 is set. It is usable for a user access (`req_user`=1) only if upper bit 0 is set.
- R6: On a hit, `rsp_paddr[31:28]` is lower bits [31:28]. `rsp_paddr[27:17]` is lower bits [27:17] OR-ed with the address bits [27:17] selected by the mask. `rsp_paddr[16:12]` is address bits [16:12], and `rsp_paddr[11:0]` is 0.
- R7: Lower bit 1 set grants read and write. Otherwise lower bit 0 set grants read only. With neither bit set, no access is granted. On a hit, `rsp_rd` and `rsp_wr` report the granted rights.
- R8: If the selected entry does not grant the requested access (a write without write rights, or a read without read rights), `rsp_prot_err`=1, `rsp_hit`=0, and `rsp_paddr`, `rsp_rd` and `rsp_wr` are 0. Every response has exactly one of hit, miss or protection error set.
- R9: If no entry is both matching and usable, `rsp_miss`=1, and `rsp_paddr`, `rsp_rd` and `rsp_wr` are 0.
- R10: When several entries match and are usable, the lowest index decides the outcome, including a protection error. An entry that is unusable at the current privilege level is skipped.
- R11: Code accesses consult only the code set, and data accesses only the data set.
- R12: A clock edge with `cfg_wr_en`=1 writes `cfg_wr_data` into entry `cfg_wr_idx` of the code set (`cfg_wr_code`=1) or the data set. It writes the upper word if `cfg_wr_upper`=1, otherwise the lower word. The new value applies to requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Entry word write strobe |
| cfg_wr_code | input | 1 | 1 = code set, 0 = data set |
| cfg_wr_idx | input | IDX_W | Entry index to write |
| cfg_wr_upper | input | 1 | 1 = upper word, 0 = lower word |
| cfg_wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| xlate_code_en | input | 1 | Translation enable for code accesses |
| xlate_data_en | input | 1 | Translation enable for data accesses |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No usable matching entry |
| rsp_prot_err | output | 1 | Selected entry forbids the access |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_paddr | output | 32 | Physical page address, bits [11:0] zero |

## Verification
The assertions check, on every cycle, the following properties. A response follows each request by exactly one cycle. Each response carries a single outcome. A miss carries no address or rights, and a hit on a write always has write rights. A disabled-translation request returns its own page address with full rights.

Only the bench's scenarios can show the rest:
- which entry wins among overlapping ones;
- the effect of the block-length mask on match and address;
- the privilege bits skipping an entry;
- the separation of code and data sets;
- how fast a write becomes visible.

The bench checks these against its own model of the written entries.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int EA_W    = 32;
    localparam int PG_LSB  = 12;

    typedef struct packed {
        logic [EA_W-1:0] upper;
        logic [EA_W-1:0] lower;
    } bat_ent_t;

    typedef struct packed {
        logic            hit;
        logic            miss;
        logic            perr;
        logic            rd;
        logic            wr;
        logic [EA_W-1:0] paddr;
    } bat_rsp_t;

    // block-length mask, aligned to address bits [27:17]
    function automatic logic [10:0] blk_mask(input logic [EA_W-1:0] up);
        return up[12:2];
    endfunction

    function automatic logic ea_match(input bat_ent_t e, input logic [EA_W-1:0] ea);
        return (ea[31:28] == e.upper[31:28]) &&
               ((ea[27:17] & ~blk_mask(e.upper)) == e.upper[27:17]);
    endfunction

    function automatic logic ent_usable(input bat_ent_t e, input logic user);
        return user ? e.upper[0] : e.upper[1];
    endfunction

    function automatic logic [EA_W-1:0] blk_paddr(input bat_ent_t e, input logic [EA_W-1:0] ea);
        return {e.lower[31:28],
                (ea[27:17] & blk_mask(e.upper)) | e.lower[27:17],
                ea[16:12],
                {PG_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/bat_regs.sv
module bat_regs
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_code,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_upper,
    input  logic [EA_W-1:0]      wr_data,
    input  logic                 rd_code,
    output bat_ent_t             ent_o [NUM_ENT]
);

    bat_ent_t code_q [NUM_ENT];
    bat_ent_t data_q [NUM_ENT];

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            logic hit_idx;
            assign hit_idx = wr_en && (wr_idx == IDX_W'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    code_q[g] <= '0;
                    data_q[g] <= '0;
                end else if (hit_idx) begin
                    if (wr_code) begin
                        if (wr_upper) code_q[g].upper <= wr_data;
                        else          code_q[g].lower <= wr_data;
                    end else begin
                        if (wr_upper) data_q[g].upper <= wr_data;
                        else          data_q[g].lower <= wr_data;
                    end
                end
            end

            assign ent_o[g] = rd_code ? code_q[g] : data_q[g];
        end
    endgenerate

endmodule

// File: rtl/bat_match.sv
module bat_match
    import bat_pkg::*;
(
    input  bat_ent_t         ent,
    input  logic [EA_W-1:0]  ea,
    input  logic             user,
    output logic             sel,
    output logic [EA_W-1:0]  paddr,
    output logic             rd_ok,
    output logic             wr_ok
);

    logic unused_bits;
    assign unused_bits = ^{ent.upper[16:13], ent.lower[16:2], ea[11:0]};

    assign sel   = ea_match(ent, ea) && ent_usable(ent, user);
    assign paddr = blk_paddr(ent, ea);
    assign wr_ok = ent.lower[1];
    assign rd_ok = ent.lower[1] | ent.lower[0];

endmodule

// File: rtl/bat_pick.sv
module bat_pick #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_code,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic              cfg_wr_upper,
    input  logic [31:0]       cfg_wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_code,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              xlate_code_en,
    input  logic              xlate_data_en,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_prot_err,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic [31:0]       rsp_paddr
);

    bat_ent_t           ents  [NUM_ENT];
    logic [EA_W-1:0]    pa    [NUM_ENT];
    logic [NUM_ENT-1:0] sel, rdok, wrok;
    logic               any;
    logic [IDX_W-1:0]   win;
    logic               xl_en, allowed;
    bat_rsp_t           nxt, rsp_q;
    logic               vld_q;

    bat_regs #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_code  (cfg_wr_code),
        .wr_idx   (cfg_wr_idx),
        .wr_upper (cfg_wr_upper),
        .wr_data  (cfg_wr_data),
        .rd_code  (req_code),
        .ent_o    (ents)
    );

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
            bat_match u_match (
                .ent   (ents[g]),
                .ea    (req_ea),
                .user  (req_user),
                .sel   (sel[g]),
                .paddr (pa[g]),
                .rd_ok (rdok[g]),
                .wr_ok (wrok[g])
            );
        end
    endgenerate

    bat_pick #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_pick (
        .req (sel),
        .any (any),
        .idx (win)
    );

    assign xl_en   = req_code ? xlate_code_en : xlate_data_en;
    assign allowed = req_write ? wrok[win] : rdok[win];

    always_comb begin
        nxt = '0;
        if (!xl_en) begin
            nxt.hit   = 1'b1;
            nxt.rd    = 1'b1;
            nxt.wr    = 1'b1;
            nxt.paddr = {req_ea[31:PG_LSB], {PG_LSB{1'b0}}};
        end else if (any) begin
            if (allowed) begin
                nxt.hit   = 1'b1;
                nxt.rd    = rdok[win];
                nxt.wr    = wrok[win];
                nxt.paddr = pa[win];
            end else begin
                nxt.perr  = 1'b1;
            end
        end else begin
            nxt.miss = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= req_valid;
            rsp_q <= req_valid ? nxt : '0;
        end
    end

    assign rsp_valid    = vld_q;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_miss     = rsp_q.miss;
    assign rsp_prot_err = rsp_q.perr;
    assign rsp_rd       = rsp_q.rd;
    assign rsp_wr       = rsp_q.wr;
    assign rsp_paddr    = rsp_q.paddr;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_prot_err); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_err}) == 1); // R8
    AST_BYPASS_PAGE: assert property (@(posedge clk) disable iff (rst) (req_valid && !(req_code ? xlate_code_en : xlate_data_en)) |=> rsp_hit && rsp_rd && rsp_wr && rsp_paddr == {$past(req_ea[31:12]), 12'h000}); // R3
    AST_WRITE_RIGHTS: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_hit && $past(req_write)) |-> rsp_wr); // R8
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_miss) |-> (rsp_paddr == 32'h0 && !rsp_rd && !rsp_wr)); // R9
    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> rsp_paddr[11:0] == 12'h000); // R6

endmodule

// File: tb/sim_bat_xlate.sv
`timescale 1ns/1ps
module sim_bat_xlate;

    localparam int NE = 4;

    typedef struct {
        logic        hit, miss, perr, rd, wr;
        logic [31:0] paddr;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        cfg_wr_en = 0, cfg_wr_code = 0, cfg_wr_upper = 0;
    logic [1:0]  cfg_wr_idx = 0;
    logic [31:0] cfg_wr_data = 0;
    logic        req_valid = 0, req_code = 0, req_write = 0, req_user = 0;
    logic [31:0] req_ea = 0;
    logic        xlate_code_en = 1, xlate_data_en = 1;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot_err, rsp_rd, rsp_wr;
    logic [31:0] rsp_paddr;

    logic [31:0] mu_c [NE], ml_c [NE], mu_d [NE], ml_d [NE];
    exp_t        exp_q [$];
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    bat_xlate #(.NUM_ENT(NE)) u0 (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_code(cfg_wr_code), .cfg_wr_idx(cfg_wr_idx),
        .cfg_wr_upper(cfg_wr_upper), .cfg_wr_data(cfg_wr_data),
        .req_valid(req_valid), .req_ea(req_ea), .req_code(req_code),
        .req_write(req_write), .req_user(req_user),
        .xlate_code_en(xlate_code_en), .xlate_data_en(xlate_data_en),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_prot_err(rsp_prot_err), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .rsp_paddr(rsp_paddr)
    );

    function automatic exp_t model(input logic [31:0] ea, input logic code,
                                   input logic wr, input logic user, input string tag);
        exp_t e;
        logic [31:0] up, lo;
        logic [10:0] m;
        bit found = 0;
        e.hit = 0; e.miss = 0; e.perr = 0; e.rd = 0; e.wr = 0; e.paddr = 0; e.tag = tag;
        up = 0; lo = 0;
        if (!(code ? xlate_code_en : xlate_data_en)) begin
            e.hit = 1; e.rd = 1; e.wr = 1; e.paddr = {ea[31:12], 12'h000};
            return e;
        end
        for (int i = 0; i < NE; i++) begin
            logic [31:0] u;
            u = code ? mu_c[i] : mu_d[i];
            m = u[12:2];
            if (!found && ea[31:28] == u[31:28] && (ea[27:17] & ~m) == u[27:17] &&
                (user ? u[0] : u[1])) begin
                found = 1; up = u; lo = code ? ml_c[i] : ml_d[i];
            end
        end
        if (!found) begin
            e.miss = 1;
        end else if (wr ? lo[1] : (lo[1] | lo[0])) begin
            e.hit = 1; e.rd = lo[1] | lo[0]; e.wr = lo[1];
            e.paddr = {lo[31:28], (ea[27:17] & up[12:2]) | lo[27:17], ea[16:12], 12'h000};
        end else begin
            e.perr = 1;
        end
        return e;
    endfunction

    task automatic lookup(input logic [31:0] ea, input logic code, input logic wr,
                          input logic user, input string tag);
        @(negedge clk);
        req_valid = 1; req_ea = ea; req_code = code; req_write = wr; req_user = user;
        exp_q.push_back(model(ea, code, wr, user, tag));
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wcfg(input logic code, input int idx, input logic upper, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_code = code; cfg_wr_idx = 2'(idx); cfg_wr_upper = upper; cfg_wr_data = d;
        if (code) begin if (upper) mu_c[idx] = d; else ml_c[idx] = d; end
        else      begin if (upper) mu_d[idx] = d; else ml_d[idx] = d; end
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected response: actual valid=1 expected none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_prot_err !== e.perr ||
                    rsp_rd !== e.rd || rsp_wr !== e.wr || rsp_paddr !== e.paddr) begin
                    n_bad++;
                    $display("FAIL %s actual h%b m%b p%b r%b w%b pa=%h expected h%b m%b p%b r%b w%b pa=%h",
                             e.tag, rsp_hit, rsp_miss, rsp_prot_err, rsp_rd, rsp_wr, rsp_paddr,
                             e.hit, e.miss, e.perr, e.rd, e.wr, e.paddr);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin mu_c[i] = 0; ml_c[i] = 0; mu_d[i] = 0; ml_d[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_prot_err !== 0) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual v%b h%b m%b p%b expected 0000",
                     rsp_valid, rsp_hit, rsp_miss, rsp_prot_err);
        end
        // R1: cleared entries miss
        lookup(32'h8001_3456, 0, 0, 0, "R1 data miss after reset");
        lookup(32'h8001_3456, 1, 0, 1, "R1 code miss after reset");
        // R3: bypass per access type
        xlate_data_en = 0;
        lookup(32'h1234_5ABC, 0, 1, 1, "R3 data bypass");
        lookup(32'h1234_5ABC, 1, 0, 0, "R3 code still translated");
        xlate_data_en = 1; xlate_code_en = 0;
        lookup(32'hFFFF_FFFF, 1, 1, 1, "R3 code bypass");
        xlate_code_en = 1;
        // R6 R7: data entry 0, 128KB block, both privileges, read/write
        wcfg(0, 0, 1, 32'h8000_0003);
        wcfg(0, 0, 0, 32'h0010_0002);
        lookup(32'h8001_3456, 0, 0, 1, "R6 paddr user read");
        lookup(32'h8001_3456, 0, 1, 0, "R7 rw write");
        // R4 negatives
        lookup(32'h8004_0000, 0, 0, 0, "R4 bit outside mask");
        lookup(32'h9001_0000, 0, 0, 0, "R4 top nibble");
        // R4 full mask, supervisor only, read only
        wcfg(0, 1, 1, 32'h9000_1FFE);
        wcfg(0, 1, 0, 32'hA000_0001);
        lookup(32'h9ABC_DEF0, 0, 0, 0, "R4 full mask hit");
        lookup(32'h9ABC_DEF0, 0, 0, 1, "R5 user skip");
        lookup(32'h9ABC_DEF0, 0, 1, 0, "R8 write to read-only");
        // R7 no access and R10 priority
        wcfg(0, 2, 1, 32'hC000_0003);
        wcfg(0, 2, 0, 32'h0000_0000);
        wcfg(0, 3, 1, 32'hC000_0003);
        wcfg(0, 3, 0, 32'h5000_0002);
        lookup(32'hC000_1000, 0, 0, 0, "R7 no access read");
        lookup(32'hC000_1000, 0, 0, 1, "R10 lower index wins");
        wcfg(0, 2, 1, 32'hC000_0002);
        lookup(32'hC000_1000, 0, 0, 1, "R10 unusable entry skipped");
        lookup(32'hC000_1000, 0, 0, 0, "R10 supervisor lower wins");
        // R11 separate sets
        lookup(32'h8001_3456, 1, 0, 0, "R11 code ignores data set");
        wcfg(1, 0, 1, 32'h8000_0003);
        wcfg(1, 0, 0, 32'h7000_0002);
        lookup(32'h8001_3456, 1, 0, 0, "R11 code set hit");
        lookup(32'h8001_3456, 0, 0, 0, "R11 data set unchanged");
        // R12 write then immediate use
        wcfg(0, 0, 0, 32'h0020_0001);
        lookup(32'h8001_3456, 0, 0, 0, "R12 new lower read");
        lookup(32'h8001_3456, 0, 1, 0, "R12 new lower write");
        // R4 partial mask
        wcfg(0, 1, 1, 32'h9000_0006);
        wcfg(0, 1, 0, 32'hA000_0002);
        lookup(32'h9002_0000, 0, 0, 0, "R4 mask bit used");
        lookup(32'h9004_0000, 0, 0, 0, "R4 unmasked bit miss");
        repeat (3) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing responses actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule